// File: doc/BRIEF.md
# Flash block erase-verify sequencer

This block runs the full erase of one flash block and then proves the block blank. It walks the flash array's control strobes through a fixed raise/wait/drop order: software-write enable, erase setup, the erase pulse itself and erase-verify mode. Every step has its own programmable delay, and a single shared down-counter times all of them. While the setup and pulse strobes are live, the block holds a watchdog enable high. It also presents a one-hot block select to the array.

After each pulse the sequencer enters verify mode and checks the block word by word. For each word it issues a dummy write of 0x00FF to the word's byte address, waits a settling time and reads back 16 bits. A word passes only when it reads all ones. The first failing word ends the pass, and the block is erased again. After a set number of attempts the sequencer reports failure. No pre-programming to zeros is done before the erase.

The surrounding logic starts one block at a time. It pulses a start request with a one-hot block select and the byte addresses of the block's first and last words. It then waits for a one-cycle done or fail flag. All delays and the attempt limit are parameters given in clock cycles.

Top module: `blkEraseSeq`

## Requirements
- R1: A start request is accepted only when `blkSel` has exactly one bit set. With zero bits or two or more bits set, `busy` stays low and no strobe moves. While running, `blkSelOut` never has more than one bit set.
- R2: After acceptance, `swEn` rises. T_SSWE cycles later, `blkSelOut` (the latched select), `wdtEn` and `setupStb` rise in the same cycle. T_SESU cycles after that, `pulseStb` rises and stays high for exactly T_SE cycles.
- R3: When the pulse drops, `setupStb` falls T_CE cycles later. T_CESU cycles after that fall, `verifyMode` rises and `wdtEn` falls in the same cycle.
- R4: While `verifyMode` is high, `setupStb` and `wdtEn` are low. The first dummy write comes T_SEV cycles after `verifyMode` rises, and its address is `blkStart`.
- R5: Each verify word takes one cycle of `memWrEn` with `memWrData` = 0x00FF, then T_SEVR cycles of wait, then one cycle of `memRdEn`. `memRdData` is sampled in the `memRdEn` cycle. `memWrEn` is asserted only in verify mode.
- R6: A word passes only when it reads 0xFFFF. A passing word whose address differs from `blkEnd` advances the address by 2 for the next word. The address `blkEnd` is the last word checked.
- R7: When the word at `blkEnd` passes, `verifyMode` falls. T_CEV cycles later `swEn` falls, and T_CSWE cycles after that `done` is high for exactly one cycle.
- R8: The first failing word ends the pass, and `verifyMode` falls. If fewer than MAX_TRY pulses have been given, then T_CEV cycles later `setupStb` and `wdtEn` rise again and a new pulse follows.
- R9: If the failing pass follows pulse number MAX_TRY, then `swEn` falls T_CEV cycles after `verifyMode` falls. T_CSWE cycles later `fail` is high for one cycle, after exactly MAX_TRY pulses.
- R10: `busy` is high from the cycle after acceptance until `done` or `fail` is pulsed, and is low in that cycle. A start request arriving while `busy` is high changes neither the latched select nor the outcome.
- R11: When idle, `swEn`, `setupStb`, `pulseStb`, `verifyMode`, `wdtEn`, `memWrEn`, `memRdEn` and `blkSelOut` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to erase a block |
| blkSel | input | BLK_N | One-hot block select for the request |
| blkStart | input | ADDR_W | Byte address of the block's first word |
| blkEnd | input | ADDR_W | Byte address of the block's last word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: block erased and verified |
| fail | output | 1 | One-cycle pulse: attempt limit reached |
| swEn | output | 1 | Software-write enable to the array |
| setupStb | output | 1 | Erase setup strobe |
| pulseStb | output | 1 | Erase pulse strobe |
| verifyMode | output | 1 | Erase-verify mode strobe |
| wdtEn | output | 1 | Watchdog enable |
| blkSelOut | output | BLK_N | One-hot block select to the array |
| memWrEn | output | 1 | Dummy write strobe |
| memRdEn | output | 1 | Verify read strobe |
| memAddr | output | ADDR_W | Verify byte address |
| memWrData | output | DATA_W | Dummy write data (0x00FF) |
| memRdData | input | DATA_W | Verify read data |

## Verification
A block model counts erase pulses and holds one chosen word at a value with a single zero bit until a chosen number of pulses has been given. Varying that count and the bad word's position separates four cases: a clean first pass, recovery after a retry, a bad last word (which tests the end-of-block compare), and exhaustion of the attempt limit. A single-word block and a request that arrives mid-run cover the address boundary and the busy case. Requests with zero or two select bits show whether the one-hot check gates the start.

// File: rtl/eraseSeqPkg.sv
package eraseSeqPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SWE, ST_SETUP, ST_PULSE, ST_CE, ST_CESU, ST_SEV, ST_DWR,
    ST_SEVR, ST_READ, ST_CEV_OK, ST_CSWE_OK, ST_DONE, ST_CEV_BAD, ST_CSWE_BAD, ST_FAIL
  } seqState_e;

  typedef enum logic [3:0] {
    D_SSWE, D_SESU, D_SE, D_CE, D_CESU, D_SEV, D_SEVR, D_CEV, D_CSWE
  } delaySel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      accept;
    logic      tmrLoad;
    delaySel_e tmrSel;
    logic      addrInit;
    logic      addrNext;
    logic      tryNext;
    logic      selOn;
  } dpCtl_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eraseSeqCtrl.sv
module eraseSeqCtrl
  import eraseSeqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   selValid,
  input  logic   tmrZero,
  input  logic   wordOk,
  input  logic   lastWord,
  input  logic   tryAtLimit,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done,
  output logic   fail,
  output logic   swEn,
  output logic   setupStb,
  output logic   pulseStb,
  output logic   verifyMode,
  output logic   wdtEn,
  output logic   memWrEn,
  output logic   memRdEn
);

  seqState_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    ctl = '0;
    case (state)
      ST_IDLE: if (startReq && selValid) begin
        ctl.accept = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = D_SSWE; nxt = ST_SWE;
      end
      ST_SWE: if (tmrZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_SESU; nxt = ST_SETUP;
      end
      ST_SETUP: if (tmrZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_SE; nxt = ST_PULSE;
      end
      ST_PULSE: if (tmrZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_CE; nxt = ST_CE;
      end
      ST_CE: if (tmrZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_CESU; nxt = ST_CESU;
      end
      ST_CESU: if (tmrZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_SEV; nxt = ST_SEV;
      end
      ST_SEV: if (tmrZero) begin
        ctl.addrInit = 1'b1; nxt = ST_DWR;
      end
      ST_DWR: begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_SEVR; nxt = ST_SEVR;
      end
      ST_SEVR: if (tmrZero) nxt = ST_READ;
      ST_READ: begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_CEV;
        if (!wordOk)       nxt = ST_CEV_BAD;
        else if (lastWord) nxt = ST_CEV_OK;
        else begin
          ctl.tmrLoad = 1'b0; ctl.addrNext = 1'b1; nxt = ST_DWR;
        end
      end
      ST_CEV_OK: if (tmrZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = D_CSWE; nxt = ST_CSWE_OK;
      end
      ST_CSWE_OK: if (tmrZero) nxt = ST_DONE;
      ST_CEV_BAD: if (tmrZero) begin
        ctl.tmrLoad = 1'b1;
        if (tryAtLimit) begin
          ctl.tmrSel = D_CSWE; nxt = ST_CSWE_BAD;
        end else begin
          ctl.tmrSel = D_SESU; ctl.tryNext = 1'b1; nxt = ST_SETUP;
        end
      end
      ST_CSWE_BAD: if (tmrZero) nxt = ST_FAIL;
      ST_DONE: nxt = ST_IDLE;
      ST_FAIL: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    ctl.selOn = !(state inside {ST_IDLE, ST_SWE, ST_DONE, ST_FAIL});
  end

  always_comb begin
    busy       = !(state inside {ST_IDLE, ST_DONE, ST_FAIL});
    done       = (state == ST_DONE);
    fail       = (state == ST_FAIL);
    swEn       = state inside {ST_SWE, ST_SETUP, ST_PULSE, ST_CE, ST_CESU, ST_SEV,
                               ST_DWR, ST_SEVR, ST_READ, ST_CEV_OK, ST_CEV_BAD};
    setupStb   = state inside {ST_SETUP, ST_PULSE, ST_CE};
    pulseStb   = (state == ST_PULSE);
    wdtEn      = state inside {ST_SETUP, ST_PULSE, ST_CE, ST_CESU};
    verifyMode = state inside {ST_SEV, ST_DWR, ST_SEVR, ST_READ};
    memWrEn    = (state == ST_DWR);
    memRdEn    = (state == ST_READ);
  end

endmodule

// File: rtl/eraseSeqDp.sv
module eraseSeqDp
  import eraseSeqPkg::*;
#(
  parameter int BLK_N   = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int MAX_TRY = 3,
  parameter int T_SSWE  = 2,
  parameter int T_SESU  = 3,
  parameter int T_SE    = 10,
  parameter int T_CE    = 2,
  parameter int T_CESU  = 2,
  parameter int T_SEV   = 3,
  parameter int T_SEVR  = 2,
  parameter int T_CEV   = 2,
  parameter int T_CSWE  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BLK_N-1:0]  blkSel,
  input  logic [ADDR_W-1:0] blkStart,
  input  logic [ADDR_W-1:0] blkEnd,
  input  logic [DATA_W-1:0] memRdData,
  output logic              selValid,
  output logic              tmrZero,
  output logic              wordOk,
  output logic              lastWord,
  output logic              tryAtLimit,
  output logic [BLK_N-1:0]  blkSelOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData
);

  localparam int TRY_W = $clog2(MAX_TRY + 1);

  logic [BLK_N-1:0]  selLat;
  logic [ADDR_W-1:0] startLat, endLat, curAddr;
  logic [CNT_W-1:0]  tmrCnt, tmrInit;
  logic [TRY_W-1:0]  tryCnt;

  always_comb begin
    case (ctl.tmrSel)
      D_SSWE:  tmrInit = CNT_W'(T_SSWE - 1);
      D_SESU:  tmrInit = CNT_W'(T_SESU - 1);
      D_SE:    tmrInit = CNT_W'(T_SE - 1);
      D_CE:    tmrInit = CNT_W'(T_CE - 1);
      D_CESU:  tmrInit = CNT_W'(T_CESU - 1);
      D_SEV:   tmrInit = CNT_W'(T_SEV - 1);
      D_SEVR:  tmrInit = CNT_W'(T_SEVR - 1);
      D_CEV:   tmrInit = CNT_W'(T_CEV - 1);
      D_CSWE:  tmrInit = CNT_W'(T_CSWE - 1);
      default: tmrInit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selLat   <= '0;
      startLat <= '0;
      endLat   <= '0;
      curAddr  <= '0;
      tmrCnt   <= '0;
      tryCnt   <= '0;
    end else begin
      if (ctl.accept) begin
        selLat   <= blkSel;
        startLat <= blkStart;
        endLat   <= blkEnd;
        tryCnt   <= TRY_W'(1);
      end else if (ctl.tryNext) begin
        tryCnt <= tryCnt + 1'b1;
      end
      if (ctl.tmrLoad)             tmrCnt <= tmrInit;
      else if (tmrCnt != '0)       tmrCnt <= tmrCnt - 1'b1;
      if (ctl.addrInit)            curAddr <= startLat;
      else if (ctl.addrNext)       curAddr <= curAddr + ADDR_W'(2);
    end
  end

  assign selValid   = $onehot(blkSel);
  assign tmrZero    = (tmrCnt == '0);
  assign wordOk     = &memRdData;
  assign lastWord   = (curAddr == endLat);
  assign tryAtLimit = (tryCnt >= TRY_W'(MAX_TRY));
  assign blkSelOut  = ctl.selOn ? selLat : '0;
  assign memAddr    = curAddr;
  assign memWrData  = DATA_W'(8'hFF);

endmodule

// File: rtl/blkEraseSeq.sv
module blkEraseSeq
  import eraseSeqPkg::*;
#(
  parameter int BLK_N   = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int MAX_TRY = 3,
  parameter int T_SSWE  = 2,
  parameter int T_SESU  = 3,
  parameter int T_SE    = 10,
  parameter int T_CE    = 2,
  parameter int T_CESU  = 2,
  parameter int T_SEV   = 3,
  parameter int T_SEVR  = 2,
  parameter int T_CEV   = 2,
  parameter int T_CSWE  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [BLK_N-1:0]  blkSel,
  input  logic [ADDR_W-1:0] blkStart,
  input  logic [ADDR_W-1:0] blkEnd,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              swEn,
  output logic              setupStb,
  output logic              pulseStb,
  output logic              verifyMode,
  output logic              wdtEn,
  output logic [BLK_N-1:0]  blkSelOut,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  localparam int WAIT_MAX = max2(max2(max2(T_SSWE, T_SESU), max2(T_SE, T_CE)),
                                 max2(max2(T_CESU, T_SEV), max2(max2(T_SEVR, T_CEV), T_CSWE)));
  localparam int CNT_W = $clog2(WAIT_MAX + 1);

  dpCtl_t ctl;
  logic   selValid, tmrZero, wordOk, lastWord, tryAtLimit;

  eraseSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .selValid(selValid),
    .tmrZero(tmrZero), .wordOk(wordOk), .lastWord(lastWord), .tryAtLimit(tryAtLimit),
    .ctl(ctl), .busy(busy), .done(done), .fail(fail), .swEn(swEn),
    .setupStb(setupStb), .pulseStb(pulseStb), .verifyMode(verifyMode),
    .wdtEn(wdtEn), .memWrEn(memWrEn), .memRdEn(memRdEn)
  );

  eraseSeqDp #(
    .BLK_N(BLK_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_TRY(MAX_TRY),
    .T_SSWE(T_SSWE), .T_SESU(T_SESU), .T_SE(T_SE), .T_CE(T_CE), .T_CESU(T_CESU),
    .T_SEV(T_SEV), .T_SEVR(T_SEVR), .T_CEV(T_CEV), .T_CSWE(T_CSWE)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .blkSel(blkSel), .blkStart(blkStart),
    .blkEnd(blkEnd), .memRdData(memRdData), .selValid(selValid), .tmrZero(tmrZero),
    .wordOk(wordOk), .lastWord(lastWord), .tryAtLimit(tryAtLimit),
    .blkSelOut(blkSelOut), .memAddr(memAddr), .memWrData(memWrData)
  );

endmodule

// File: rtl/eraseSeqChk.sv
module eraseSeqChk #(
  parameter int BLK_N   = 8,
  parameter int DATA_W  = 16,
  parameter int MAX_TRY = 3,
  parameter int T_SE    = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              swEn,
  input logic              setupStb,
  input logic              pulseStb,
  input logic              verifyMode,
  input logic              wdtEn,
  input logic [BLK_N-1:0]  blkSelOut,
  input logic              memWrEn,
  input logic              memRdEn,
  input logic [DATA_W-1:0] memWrData
);

  logic        idleNow, pulsePrev;
  logic [31:0] hiCnt;
  logic [7:0]  pulseCnt;

  assign idleNow = !busy && !done && !fail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt     <= '0;
      pulseCnt  <= '0;
      pulsePrev <= 1'b0;
    end else begin
      hiCnt     <= pulseStb ? hiCnt + 1 : '0;
      pulsePrev <= pulseStb;
      if (idleNow)                     pulseCnt <= '0;
      else if (pulseStb && !pulsePrev) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(blkSelOut));
  // R2
  pulse_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseStb |-> (setupStb && swEn && wdtEn && blkSelOut != '0));
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseStb) |-> (hiCnt == 32'(T_SE)));
  // R4
  verify_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    verifyMode |-> (!setupStb && !wdtEn && !pulseStb));
  // R5
  dummy_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (verifyMode && !memRdEn && memWrData == DATA_W'(8'hFF)));
  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R9
  fail_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (pulseCnt == 8'(MAX_TRY)));
  // R10
  end_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail) |-> (!busy && !(done && fail)));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleNow |-> (!swEn && !setupStb && !pulseStb && !verifyMode && !wdtEn &&
                 !memWrEn && !memRdEn && blkSelOut == '0));

endmodule

bind blkEraseSeq eraseSeqChk #(
  .BLK_N(BLK_N), .DATA_W(DATA_W), .MAX_TRY(MAX_TRY), .T_SE(T_SE)
) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .fail(fail), .swEn(swEn),
  .setupStb(setupStb), .pulseStb(pulseStb), .verifyMode(verifyMode), .wdtEn(wdtEn),
  .blkSelOut(blkSelOut), .memWrEn(memWrEn), .memRdEn(memRdEn), .memWrData(memWrData)
);

// File: tb/tb_blkEraseSeq.sv
module tb_blkEraseSeq;

  localparam int BLK_N = 8, ADDR_W = 16, DATA_W = 16, MAX_TRY = 3;
  localparam int T_SSWE = 2, T_SESU = 3, T_SE = 10, T_CE = 2, T_CESU = 2;
  localparam int T_SEV = 3, T_SEVR = 2, T_CEV = 2, T_CSWE = 2;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0;
  logic [BLK_N-1:0] blkSel = '0, blkSelOut;
  logic [ADDR_W-1:0] blkStart = '0, blkEnd = '0, memAddr;
  logic [DATA_W-1:0] memWrData, memRdData;
  logic busy, done, fail, swEn, setupStb, pulseStb, verifyMode, wdtEn, memWrEn, memRdEn;

  always #10 clk = ~clk;

  blkEraseSeq #(
    .BLK_N(BLK_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_TRY(MAX_TRY),
    .T_SSWE(T_SSWE), .T_SESU(T_SESU), .T_SE(T_SE), .T_CE(T_CE), .T_CESU(T_CESU),
    .T_SEV(T_SEV), .T_SEVR(T_SEVR), .T_CEV(T_CEV), .T_CSWE(T_CSWE)
  ) dut (.*);

  typedef struct { bit isDone; int pulses; int reads; } exp_t;
  exp_t expQ[$];

  int checks = 0, failures = 0, cyc = 0;
  int pulseCnt = 0, rdCnt = 0, needPulses = 1, badIdx = -1, opStart = 0, wIdx = 0;
  logic [BLK_N-1:0] expSel = '0;
  int tSweRise, tSetupRise, tPulseRise, tPulseFall, tSetupFall, tVerRise, tVerFall, tSwFall, tWr;
  logic pSw = 0, pSetup = 0, pPulse = 0, pVer = 0;

  // block model: one word stays bad until enough pulses have been given
  assign memRdData = (pulseCnt >= needPulses || ((int'(memAddr) - opStart) / 2) != badIdx)
                     ? 16'hFFFF : 16'hFF7F;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // monitor: strobe timing and scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (swEn && !pSw) tSweRise = cyc;
      if (setupStb && !pSetup) begin
        if (pulseCnt == 0) chk(cyc - tSweRise == T_SSWE, "R2", "swEn->setup", cyc - tSweRise, T_SSWE);
        else chk(cyc - tVerFall == T_CEV, "R8", "verify fall->setup", cyc - tVerFall, T_CEV);
        chk(wdtEn && swEn && blkSelOut == expSel, "R2", "sel/wdt at setup", int'(blkSelOut), int'(expSel));
        tSetupRise = cyc;
      end
      if (pulseStb && !pPulse) begin
        pulseCnt++;
        chk(cyc - tSetupRise == T_SESU, "R2", "setup->pulse", cyc - tSetupRise, T_SESU);
        tPulseRise = cyc;
      end
      if (!pulseStb && pPulse) begin
        chk(cyc - tPulseRise == T_SE, "R2", "pulse width", cyc - tPulseRise, T_SE);
        tPulseFall = cyc;
      end
      if (!setupStb && pSetup) begin
        chk(cyc - tPulseFall == T_CE, "R3", "pulse->setup fall", cyc - tPulseFall, T_CE);
        tSetupFall = cyc;
      end
      if (verifyMode && !pVer) begin
        chk(cyc - tSetupFall == T_CESU, "R3", "setup fall->verify", cyc - tSetupFall, T_CESU);
        chk(!wdtEn, "R3", "wdt off in verify", int'(wdtEn), 0);
        tVerRise = cyc;
        wIdx = 0;
      end
      if (!verifyMode && pVer) tVerFall = cyc;
      if (memWrEn) begin
        chk(memWrData == 16'h00FF && verifyMode, "R5", "dummy write data", int'(memWrData), 255);
        if (wIdx == 0) chk(cyc - tVerRise == T_SEV, "R4", "verify->first write", cyc - tVerRise, T_SEV);
        tWr = cyc;
      end
      if (memRdEn) begin
        chk(int'(memAddr) == opStart + 2 * wIdx, "R6", "verify address", int'(memAddr), opStart + 2 * wIdx);
        chk(cyc - tWr == T_SEVR + 1, "R5", "write->read", cyc - tWr, T_SEVR + 1);
        chk(!wdtEn && !setupStb, "R4", "quiet during read", int'(wdtEn), 0);
        wIdx++;
        rdCnt++;
      end
      if (!swEn && pSw) begin
        chk(cyc - tVerFall == T_CEV, "R7", "verify fall->swEn fall", cyc - tVerFall, T_CEV);
        tSwFall = cyc;
      end
      if (done || fail) begin
        exp_t e;
        chk(cyc - tSwFall == T_CSWE, "R9", "swEn fall->flag", cyc - tSwFall, T_CSWE);
        chk(!busy, "R10", "busy low with flag", int'(busy), 0);
        if (expQ.size() == 0) chk(0, "R10", "unexpected flag", 1, 0);
        else begin
          e = expQ.pop_front();
          chk(done == e.isDone && fail == !e.isDone, "R7", "outcome done", int'(done), int'(e.isDone));
          chk(pulseCnt == e.pulses, "R8", "pulse count", pulseCnt, e.pulses);
          chk(rdCnt == e.reads, "R6", "read count", rdCnt, e.reads);
        end
      end
    end
    pSw = swEn; pSetup = setupStb; pPulse = pulseStb; pVer = verifyMode;
  end

  task automatic checkIdle(string req);
    chk(!busy && !swEn && !setupStb && !pulseStb && !verifyMode && !wdtEn && !memWrEn &&
        !memRdEn && blkSelOut == '0, req, "idle outputs low", int'(busy) + int'(swEn), 0);
  endtask

  // driver: computes the expected outcome and starts one block
  task automatic runOp(logic [BLK_N-1:0] sel, int sAddr, int eAddr, int need, int bad, bit poke);
    exp_t e;
    int words = (eAddr - sAddr) / 2 + 1;
    if (bad < 0 || need <= 1) begin e.isDone = 1; e.pulses = 1; e.reads = words; end
    else if (need <= MAX_TRY) begin e.isDone = 1; e.pulses = need; e.reads = (need - 1) * (bad + 1) + words; end
    else begin e.isDone = 0; e.pulses = MAX_TRY; e.reads = MAX_TRY * (bad + 1); end
    expQ.push_back(e);
    pulseCnt = 0; rdCnt = 0; needPulses = need; badIdx = bad; opStart = sAddr; expSel = sel;
    @(negedge clk);
    startReq = 1; blkSel = sel; blkStart = ADDR_W'(sAddr); blkEnd = ADDR_W'(eAddr);
    @(negedge clk);
    startReq = 0; blkSel = '0;
    chk(busy, "R10", "busy after accept", int'(busy), 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      startReq = 1; blkSel = 8'h01;
      @(negedge clk);
      startReq = 0; blkSel = '0;
    end
    while (!(done || fail)) @(negedge clk);
    repeat (3) @(negedge clk);
    checkIdle("R11");
    chk(expQ.size() == 0, "R10", "scoreboard drained", expQ.size(), 0);
  endtask

  task automatic tryReject(logic [BLK_N-1:0] sel);
    @(negedge clk);
    startReq = 1; blkSel = sel; blkStart = 16'h0010; blkEnd = 16'h0012;
    @(negedge clk);
    startReq = 0; blkSel = '0;
    repeat (8) @(negedge clk);
    chk(!busy && !swEn, "R1", "bad select rejected", int'(busy), 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R10 watchdog expired act=0 exp=1");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R11");
    chk(!done && !fail, "R11", "flags low in reset", int'(done) + int'(fail), 0);
    rstN = 1;
    @(negedge clk);
    checkIdle("R11");
    tryReject(8'h00);                          // R1 zero bits
    tryReject(8'h06);                          // R1 two bits
    runOp(8'h04, 16'h20, 16'h2E, 1, -1, 0);    // R6 clean first pass
    runOp(8'h02, 16'h20, 16'h2E, 2, 3, 0);     // R8 one retry
    runOp(8'h10, 16'h20, 16'h2E, 3, 7, 0);     // R6 bad last word, limit reached exactly
    runOp(8'h08, 16'h60, 16'h66, 5, 0, 0);     // R9 attempt limit exhausted
    runOp(8'h01, 16'h40, 16'h40, 2, 0, 0);     // R6 single-word block
    runOp(8'h80, 16'h80, 16'h86, 2, 1, 1);     // R10 start while busy ignored
    repeat (4) @(negedge clk);
    chk(!busy, "R10", "no start from ignored request", int'(busy), 0);
    finishRun();
  end

endmodule